// File: doc/BRIEF.md
# ADC Single-Conversion Control Sequencer

This block is the digital control side of a successive-approximation converter used one conversion at a time. A processor programs a byte-wide control/status register over a simple register bus. The register selects an input channel and a conversion clock, enables an interrupt, and starts a conversion. The sequencer counts a fixed number of clocks for the chosen clock rate. On the last clock it captures a 10-bit value from a digital stand-in input. It stores that value in the result register belonging to the channel, raises a done flag and stops.

The done flag drives an interrupt request when the interrupt is enabled. A data-transfer engine can service the request with an acknowledge pulse, which clears the flag at once. A processor clears the flag itself through a guarded read-then-write sequence. Software can abort a running conversion by writing the start bit low. Attempts to change channel or clock in mid-conversion are ignored and recorded in a sticky error output.

Top module: `adc_single_seq`

## Requirements
- R1: After reset the control/status register reads 0x00, every result register reads 0, and both `conv_irq` and `cfg_err` are 0.
- R2: A write to the control/status register (address 4) with bit 5 set, while idle, starts one conversion. Bit 5 reads 1 for the whole conversion and is cleared by hardware when the conversion finishes.
- R3: With bit 3 = 0 the conversion finishes on the 266th rising edge after the starting write's edge. With bit 3 = 1 it finishes on the 134th.
- R4: The sample on `adc_sample` at the finishing edge is written to the result register at address ch mod 4, where ch is bits 2:0. The other result registers keep their values.
- R5: At finish, bit 7 (done) becomes 1 and `conv_irq` equals done AND bit 6 (interrupt enable).
- R6: A one-cycle `xfer_ack` pulse clears done on the next edge without any register write.
- R7: A write with bit 7 = 0 clears done only if the register was read while done was 1, after done was last set. A write with bit 7 = 1 never changes done.
- R8: Writing the register with bit 5 = 0 during a conversion aborts it. Bit 5 reads 0, no result register changes and done stays 0.
- R9: A write with bit 5 = 1 during a conversion whose bits 4:0 differ from the running settings leaves those settings unchanged and sets `cfg_err`. `cfg_err` then stays 1 until reset.
- R10: After a conversion ends the block stays idle and does not start another one by itself.
- R11: A single write of 0x61 starts a slow-clock conversion on channel 1 with the interrupt enabled, and the result lands in result register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reading address 4 arms the done clear) |
| bus_addr | input | 3 | Register address: 0..3 results, 4 control/status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register, combinational |
| xfer_ack | input | 1 | Transfer-engine acknowledge pulse |
| adc_sample | input | 10 | Digital stand-in for the converter output |
| conv_irq | output | 1 | Conversion-end interrupt request |
| cfg_err | output | 1 | Sticky mid-conversion settings-change error |

## Verification
Embedded assertions check on every cycle the protocol-level rules: the done flag rises only on a finishing conversion, done cannot be cleared when the clear is not armed, an acknowledge always clears it, the error bit never falls, the timer never restarts without a start request, and result registers hold unless written. The exact conversion lengths for both clock settings, the routing of a sample to the right result register, the read-then-write clearing order, aborts that leave results untouched, and ignored settings changes are shown only by the directed bench scenarios. Those scenarios compare register reads and port values against counted cycle positions.

// File: rtl/adc_seq_pkg.sv
// Shared field positions and types for the single-conversion sequencer.
// Assumes an 8-bit control/status register layout fixed by software.
package adc_seq_pkg;
    localparam int CSR_W     = 8;
    localparam int DONE_BIT  = 7;
    localparam int IE_BIT    = 6;
    localparam int START_BIT = 5;
    localparam int MODE_BIT  = 4;
    localparam int CKS_BIT   = 3;
    localparam int CH_W      = 3;

    // Settings latched for a conversion
    typedef struct packed {
        logic            mode;
        logic            cks;
        logic [CH_W-1:0] ch;
    } conv_cfg_t;
endpackage

// File: rtl/adc_conv_timer.sv
// Conversion timer: counts the conversion length picked at start time and
// emits a one-cycle finish strobe on the last clock. Assumes start_req is
// only raised while idle; abort has priority over finishing.
module adc_conv_timer #(
    parameter int SLOW_CYCLES = 266,
    parameter int FAST_CYCLES = 134
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req_i,
    input  logic start_cks_i,
    input  logic abort_i,
    output logic busy_o,
    output logic finish_o
);
    localparam int MAX_CYCLES = (SLOW_CYCLES > FAST_CYCLES) ? SLOW_CYCLES : FAST_CYCLES;
    localparam int CNT_W      = $clog2(MAX_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    // Load, count down and stop the conversion counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (abort_i) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_req_i) begin
            busy_q <= 1'b1;
            cnt_q  <= start_cks_i ? CNT_W'(FAST_CYCLES - 1) : CNT_W'(SLOW_CYCLES - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Finish strobe on the final conversion clock
    always_comb begin
        finish_o = busy_q && (cnt_q == '0) && !abort_i;
    end

    assign busy_o = busy_q;

    // R10: the timer never becomes busy without a start request
    a_r10_no_self_start: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q && !start_req_i |=> !busy_q);

    // R8: an abort always leaves the timer idle
    a_r8_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !busy_q);
endmodule

// File: rtl/adc_result_bank.sv
// Result bank: one register per result slot, written with the captured
// sample when a conversion finishes. Assumes idx_i is stable at we_i.
module adc_result_bank #(
    parameter int RES_W   = 10,
    parameter int NUM_RES = 4,
    localparam int IDX_W  = $clog2(NUM_RES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_i,
    input  logic [IDX_W-1:0]               idx_i,
    input  logic [RES_W-1:0]               sample_i,
    output logic [NUM_RES-1:0][RES_W-1:0]  res_o
);
    logic [NUM_RES-1:0][RES_W-1:0] res_q;

    for (genvar g = 0; g < NUM_RES; g++) begin : g_slot
        // Capture the sample into this slot when it is addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q[g] <= '0;
            end else if (we_i && (idx_i == IDX_W'(g))) begin
                res_q[g] <= sample_i;
            end
        end
    end

    assign res_o = res_q;

    // R4/R8: no result register changes without a finishing conversion
    a_r4_hold_unless_written: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(res_q));
endmodule

// File: rtl/adc_csr.sv
// Control/status register: holds channel, mode, clock and interrupt-enable
// fields, the done flag with its read-armed clear, and the sticky error bit.
// Decodes writes into start and abort requests for the timer.
// Assumes wr_en_i / rd_en_i are already qualified by the register address.
module adc_csr
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [CSR_W-1:0] wdata_i,
    input  logic             xfer_ack_i,
    input  logic             busy_i,
    input  logic             finish_i,
    output conv_cfg_t        cfg_o,
    output logic             ie_o,
    output logic             done_o,
    output logic             err_o,
    output logic             start_req_o,
    output logic             start_cks_o,
    output logic             abort_o
);
    conv_cfg_t cfg_q;
    conv_cfg_t wcfg;
    logic      ie_q;
    logic      done_q;
    logic      armed_q;
    logic      err_q;
    logic      wr_start;
    logic      cfg_clash;

    // Decode a write into start, abort and clash conditions
    always_comb begin
        wcfg.mode   = wdata_i[MODE_BIT];
        wcfg.cks    = wdata_i[CKS_BIT];
        wcfg.ch     = wdata_i[CH_W-1:0];
        wr_start    = wdata_i[START_BIT];
        start_req_o = wr_en_i && wr_start && !busy_i;
        start_cks_o = wdata_i[CKS_BIT];
        abort_o     = wr_en_i && !wr_start && busy_i;
        cfg_clash   = wr_en_i && wr_start && busy_i && (wcfg != cfg_q);
    end

    // Settings fields: frozen while a conversion keeps running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en_i && !(busy_i && wr_start)) begin
            cfg_q <= wcfg;
        end
    end

    // Interrupt enable: writable at any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
        end else if (wr_en_i) begin
            ie_q <= wdata_i[IE_BIT];
        end
    end

    // Sticky error on a settings change in mid-conversion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (cfg_clash) begin
            err_q <= 1'b1;
        end
    end

    // Done flag and its read-armed processor clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (finish_i) begin
            done_q  <= 1'b1;
            armed_q <= 1'b0;
        end else if (xfer_ack_i) begin
            done_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (wr_en_i && !wdata_i[DONE_BIT] && armed_q) begin
            done_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (rd_en_i && done_q) begin
            armed_q <= 1'b1;
        end
    end

    assign cfg_o  = cfg_q;
    assign ie_o   = ie_q;
    assign done_o = done_q;
    assign err_o  = err_q;

    // R5: done only rises on a finishing conversion
    a_r5_done_from_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(finish_i));

    // R6: an acknowledge clears done unless a new conversion finishes
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack_i && !finish_i |=> !done_q);

    // R7: an unarmed done flag survives any processor write
    a_r7_no_unarmed_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && !armed_q && !xfer_ack_i |=> done_q);

    // R9: the error bit never falls outside reset
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R9: running settings stay put while busy and not aborted
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i && !abort_o |=> $stable(cfg_q));
endmodule

// File: rtl/adc_single_seq.sv
// Top of the single-conversion sequencer: register bus decode, read mux,
// and wiring of the control/status register, conversion timer and result
// bank. Assumes one bus access per cycle; read data is combinational.
module adc_single_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int NUM_RES     = 4,
    parameter int SLOW_CYCLES = 266,
    parameter int FAST_CYCLES = 134,
    parameter int ADDR_W      = 3,
    parameter int RDATA_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CSR_W-1:0]   bus_wdata,
    output logic [RDATA_W-1:0] bus_rdata,
    input  logic               xfer_ack,
    input  logic [RES_W-1:0]   adc_sample,
    output logic               conv_irq,
    output logic               cfg_err
);
    localparam int IDX_W    = $clog2(NUM_RES);
    localparam int CSR_ADDR = NUM_RES;

    logic                          csr_sel;
    logic                          csr_wr;
    logic                          csr_rd;
    conv_cfg_t                     cfg;
    logic                          ie;
    logic                          done;
    logic                          start_req;
    logic                          start_cks;
    logic                          abort;
    logic                          busy;
    logic                          finish;
    logic [NUM_RES-1:0][RES_W-1:0] res;
    logic [CSR_W-1:0]              csr_view;

    // Address decode for the control/status register
    always_comb begin
        csr_sel = (bus_addr == ADDR_W'(CSR_ADDR));
        csr_wr  = bus_wr && csr_sel;
        csr_rd  = bus_rd && csr_sel;
    end

    adc_csr u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (csr_wr),
        .rd_en_i     (csr_rd),
        .wdata_i     (bus_wdata),
        .xfer_ack_i  (xfer_ack),
        .busy_i      (busy),
        .finish_i    (finish),
        .cfg_o       (cfg),
        .ie_o        (ie),
        .done_o      (done),
        .err_o       (cfg_err),
        .start_req_o (start_req),
        .start_cks_o (start_cks),
        .abort_o     (abort)
    );

    adc_conv_timer #(
        .SLOW_CYCLES (SLOW_CYCLES),
        .FAST_CYCLES (FAST_CYCLES)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req_i (start_req),
        .start_cks_i (start_cks),
        .abort_i     (abort),
        .busy_o      (busy),
        .finish_o    (finish)
    );

    adc_result_bank #(
        .RES_W   (RES_W),
        .NUM_RES (NUM_RES)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (finish),
        .idx_i    (cfg.ch[IDX_W-1:0]),
        .sample_i (adc_sample),
        .res_o    (res)
    );

    // Assemble the readable control/status byte; start bit reflects busy
    always_comb begin
        csr_view            = '0;
        csr_view[DONE_BIT]  = done;
        csr_view[IE_BIT]    = ie;
        csr_view[START_BIT] = busy;
        csr_view[MODE_BIT]  = cfg.mode;
        csr_view[CKS_BIT]   = cfg.cks;
        csr_view[CH_W-1:0]  = cfg.ch;
    end

    // Read data mux over results and the control/status register
    always_comb begin
        bus_rdata = '0;
        if (csr_sel) begin
            bus_rdata[CSR_W-1:0] = csr_view;
        end else if (int'(bus_addr) < NUM_RES) begin
            bus_rdata[RES_W-1:0] = res[bus_addr[IDX_W-1:0]];
        end
    end

    // Interrupt request while done and enabled
    always_comb begin
        conv_irq = done && ie;
    end

    // R2: the busy period never ends without a finish or an abort
    a_r2_start_held: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(finish) || $past(abort));
endmodule

// File: tb/sim_adc_single_seq.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_adc_single_seq;
    localparam int SLOW = 266;
    localparam int FAST = 134;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        xfer_ack = 1'b0;
    logic [9:0]  adc_sample = '0;
    logic        conv_irq;
    logic        cfg_err;

    int n_total = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    adc_single_seq u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .xfer_ack   (xfer_ack),
        .adc_sample (adc_sample),
        .conv_irq   (conv_irq),
        .cfg_err    (cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    // All bus tasks start and end just after a falling edge
    task automatic bus_write(input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ack_pulse();
        xfer_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        xfer_ack = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Start a conversion and check start bit early, late, and done at finish
    task automatic run_conv(input logic [7:0] d, input int n, input string req);
        logic [15:0] v;
        bus_write(d);
        bus_read(3'd4, v);
        check(v[5] && !v[7], req, v, {8'h0, d & 8'h7F});
        wait_n(n - 2);
        bus_read(3'd4, v);
        check(v[5] == 1'b1 && v[7] == 1'b0, {req, " R3 still running"}, v, 32'h20);
        // now just after edge t0+n: conversion complete
    endtask

    task automatic t_reset();
        logic [15:0] v;
        bus_read(3'd4, v);
        check(v == 16'h0, "R1 csr", v, 0);
        for (int i = 0; i < 4; i++) begin
            bus_read(3'(i), v);
            check(v == 16'h0, "R1 result", v, 0);
        end
        check(conv_irq == 1'b0 && cfg_err == 1'b0, "R1 irq/err", {conv_irq, cfg_err}, 0);
    endtask

    // 0x61: irq enabled, start, slow clock, channel 1
    task automatic t_slow_r11();
        logic [15:0] v;
        adc_sample = 10'h2A5;
        run_conv(8'h61, SLOW, "R2 R11 slow");
        check(conv_irq == 1'b1, "R5 irq at finish", conv_irq, 1);
        bus_read(3'd1, v);
        check(v == 16'h2A5, "R11 R4 result B", v, 16'h2A5);
        bus_read(3'd0, v);
        check(v == 16'h0, "R4 other slot", v, 0);
    endtask

    task automatic t_cpu_clear_r7();
        logic [15:0] v;
        bus_write(8'h40);
        check(conv_irq == 1'b1, "R7 unarmed write 0", conv_irq, 1);
        bus_write(8'hC0);
        check(conv_irq == 1'b1, "R7 write 1 to done", conv_irq, 1);
        bus_read(3'd4, v);
        check(v == 16'hC0, "R7 csr before clear", v, 16'hC0);
        bus_write(8'h40);
        check(conv_irq == 1'b0, "R7 armed clear irq", conv_irq, 0);
        bus_read(3'd4, v);
        check(v == 16'h40, "R7 armed clear csr", v, 16'h40);
    endtask

    task automatic t_fast_r3();
        logic [15:0] v;
        adc_sample = 10'h13C;
        run_conv(8'h28, FAST, "R2 R3 fast");
        bus_read(3'd4, v);
        check(v == 16'h88, "R3 R5 done no irq", v, 16'h88);
        check(conv_irq == 1'b0, "R5 irq masked", conv_irq, 0);
        bus_read(3'd0, v);
        check(v == 16'h13C, "R4 result A", v, 16'h13C);
        wait_n(300);
        bus_read(3'd4, v);
        check(v == 16'h88, "R10 stays idle", v, 16'h88);
    endtask

    task automatic t_ack_r6();
        logic [15:0] v;
        ack_pulse();
        bus_read(3'd4, v);
        check(v == 16'h08, "R6 ack clears done", v, 16'h08);
    endtask

    // Channel 5 maps to slot 1; acknowledged while interrupt enabled
    task automatic t_wrap_r4();
        logic [15:0] v;
        adc_sample = 10'h3F1;
        run_conv(8'h6D, FAST, "R2 wrap");
        check(conv_irq == 1'b1, "R5 irq wrap", conv_irq, 1);
        bus_read(3'd1, v);
        check(v == 16'h3F1, "R4 ch5 to slot1", v, 16'h3F1);
        ack_pulse();
        check(conv_irq == 1'b0, "R6 ack drops irq", conv_irq, 0);
        bus_read(3'd4, v);
        check(v == 16'h4D, "R6 csr after ack", v, 16'h4D);
    endtask

    task automatic t_abort_r8();
        logic [15:0] v;
        adc_sample = 10'h0AA;
        bus_write(8'h2B);
        wait_n(20);
        bus_write(8'h03);
        bus_read(3'd4, v);
        check(v == 16'h03, "R8 start reads 0", v, 16'h03);
        wait_n(200);
        bus_read(3'd4, v);
        check(v == 16'h03, "R8 no done", v, 16'h03);
        bus_read(3'd3, v);
        check(v == 16'h0, "R8 result untouched", v, 0);
    endtask

    task automatic t_change_r9();
        logic [15:0] v;
        adc_sample = 10'h155;
        bus_write(8'h2A);
        wait_n(9);
        bus_write(8'h2B);
        check(cfg_err == 1'b1, "R9 err set", cfg_err, 1);
        bus_read(3'd4, v);
        check(v == 16'h2A, "R9 settings kept", v, 16'h2A);
        wait_n(122);
        bus_read(3'd4, v);
        check(v == 16'h2A, "R3 R9 running at n-1", v, 16'h2A);
        bus_read(3'd4, v);
        check(v == 16'h8A, "R9 finish on original time", v, 16'h8A);
        bus_read(3'd2, v);
        check(v == 16'h155, "R9 result to latched ch", v, 16'h155);
        bus_read(3'd3, v);
        check(v == 16'h0, "R9 new ch unused", v, 0);
        check(cfg_err == 1'b1, "R9 err sticky", cfg_err, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_slow_r11();
        t_cpu_clear_r7();
        t_fast_r3();
        t_ack_r6();
        t_wrap_r4();
        t_abort_r8();
        t_change_r9();
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
        summary();
    end
endmodule